// File: doc/BRIEF.md
# Dual sector buffer manager

This block sits between a full-speed USB bulk endpoint engine and a media transfer coprocessor. It stages mass-storage sectors in two 512-byte banks of one single-port RAM and uses them in ping-pong fashion. One side fills a bank while the other side empties the bank that was filled before. Bytes arrive one per granted cycle, with no CPU copying. Variable-length bulk packets are gathered until a whole 512-byte sector is present, or until the USB side signals the end of a short transfer. The stored length then tells the draining side how many bytes to take. A CPU port can reach every byte of both banks at any time.

A direction input picks which side fills. With the input low (host-to-media), USB writes and the coprocessor reads. With the input high (media-to-host), the coprocessor writes and USB reads. A fixed-priority arbiter grants one RAM access per clock. A per-bank state machine holds the ownership of each bank, with states FILL (the filling side holds it) and DRAIN (the draining side holds it). The transition FILL→DRAIN happens when the last byte is written. The transition DRAIN→FILL happens when the last stored byte is read. A direction change forces both banks back to FILL. A mode register with states H2M and M2H records the direction, and the move from one of these states to the other is the clearing event.

Top module: `sector_pingpong_buf`

## Requirements
- R1: The CPU port addresses the whole buffer. Bit 9 of `cpu_addr` selects the bank and bits 8:0 select the byte offset. A granted CPU write stores `cpu_wdata`, and a granted CPU read returns that byte on `rd_data`.
- R2: At most one of `cpu_gnt`, `usb_gnt`, `dtc_gnt` is high in any cycle. A CPU request is always granted in the same cycle, and it blocks both other ports.
- R3: When the CPU is idle and both the USB and coprocessor requests are eligible, USB is granted and the coprocessor waits.
- R4: With `dir_m2h`=0, USB fills and the coprocessor drains. With `dir_m2h`=1, the coprocessor fills and USB drains. The filling side writes its bank from offset 0 upward, and the draining side reads its bank from offset 0 upward.
- R5: The 512th byte written into a bank hands that bank to the draining side (owner bit 1). Filling continues at offset 0 of the other bank.
- R6: In host-to-media mode, a granted USB byte with `usb_eot`=1 closes the bank early. The bank length is then the number of bytes written, and the drain returns exactly that many bytes. `usb_eot` has no effect in the other mode.
- R7: A fill request is not granted while the fill bank is owned by the draining side. A drain request is not granted while the drain bank is owned by the filling side.
- R8: Read data appears on `rd_data` in the cycle after the read grant. After the last stored byte is read, the bank returns to the filling side (owner bit 0), and draining moves to the other bank.
- R9: `bank_irq` is high for exactly one cycle, in the cycle after each bank handover.
- R10: In the cycle where `dir_m2h` differs from its registered value, neither USB nor the coprocessor is granted. In the next cycle, both banks are owner 0, both pointers are 0 and both counters are 0.
- R11: `bank_owner`, `fill_bank`, `drain_bank`, `fill_cnt` and `drain_cnt` always show the current owners, the bank pointers and the next offset of each side.
- R12: After reset, both banks are owned by the filling side, both pointers and counters are 0, and no grant or interrupt is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Buffer clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| dir_m2h | input | 1 | 0: USB fills / coprocessor drains; 1: reverse |
| cpu_req | input | 1 | CPU access request |
| cpu_we | input | 1 | CPU write (1) or read (0) |
| cpu_addr | input | 10 | CPU address: bank bit and offset |
| cpu_wdata | input | 8 | CPU write byte |
| cpu_gnt | output | 1 | CPU access granted this cycle |
| usb_req | input | 1 | USB byte request |
| usb_eot | input | 1 | Last byte of a short USB transfer |
| usb_wdata | input | 8 | USB write byte |
| usb_gnt | output | 1 | USB access granted this cycle |
| dtc_req | input | 1 | Coprocessor byte request |
| dtc_wdata | input | 8 | Coprocessor write byte |
| dtc_gnt | output | 1 | Coprocessor access granted this cycle |
| rd_data | output | 8 | Read byte, valid the cycle after a read grant |
| bank_irq | output | 1 | One-cycle pulse per bank handover |
| bank_owner | output | 2 | Owner bit per bank (1 = draining side) |
| fill_bank | output | 1 | Bank the filling side writes |
| drain_bank | output | 1 | Bank the draining side reads |
| fill_cnt | output | 9 | Next fill offset |
| drain_cnt | output | 9 | Next drain offset |

## Verification
The bench runs several attacks. It runs the filler against two full banks, so that a design that over-fills would overwrite sector data that has not been drained. It holds CPU traffic during streaming, so that a wrong priority order shows up as a double grant or a lost byte. It scatters short-transfer marks in both directions: a design that honours the mark in media-to-host mode would cut sectors short, and one that ignores it in host-to-media mode would drain stale bytes. It flips the direction in the middle of a stream, where a design that keeps old owners or counters would deadlock or serve a half-filled bank.

// File: rtl/spb_pkg.sv
package spb_pkg;
    typedef enum logic {
        BANK_FILL  = 1'b0,
        BANK_DRAIN = 1'b1
    } bank_state_e;

    typedef enum logic {
        MODE_H2M = 1'b0,
        MODE_M2H = 1'b1
    } xfer_mode_e;

    localparam int PORT_CPU = 0;
    localparam int PORT_USB = 1;
    localparam int PORT_DTC = 2;
    localparam int NUM_PORTS = 3;
endpackage

// File: rtl/spb_arbiter.sv
module spb_arbiter #(
    parameter int N = 3
) (
    input  logic [N-1:0] req,
    input  logic [N-1:0] ok,
    output logic [N-1:0] gnt
);
    logic taken;

    always_comb begin
        gnt   = '0;
        taken = 1'b0;
        for (int i = 0; i < N; i++) begin
            if (req[i] && ok[i] && !taken) begin
                gnt[i] = 1'b1;
                taken  = 1'b1;
            end
        end
    end
endmodule

// File: rtl/spb_bank_fsm.sv
module spb_bank_fsm
    import spb_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        clr,
    input  logic        fill_done,
    input  logic        drain_done,
    output bank_state_e state
);
    bank_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= BANK_FILL;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        if (clr) begin
            state_d = BANK_FILL;
        end else begin
            unique case (state_q)
                BANK_FILL:  if (fill_done)  state_d = BANK_DRAIN;
                BANK_DRAIN: if (drain_done) state_d = BANK_FILL;
                default:    state_d = BANK_FILL;
            endcase
        end
    end

    assign state = state_q;
endmodule

// File: rtl/spb_ram.sv
module spb_ram #(
    parameter int DEPTH = 1024,
    parameter int DW    = 8,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          en,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata
);
    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (en) begin
            if (we) mem[addr] <= wdata;
            else    rdata     <= mem[addr];
        end
    end
endmodule

// File: rtl/sector_pingpong_buf.sv
module sector_pingpong_buf
    import spb_pkg::*;
#(
    parameter int SECTOR_BYTES = 512,
    parameter int DW           = 8,
    localparam int OW          = $clog2(SECTOR_BYTES),
    localparam int AW          = OW + 1,
    localparam int CW          = OW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          dir_m2h,
    input  logic          cpu_req,
    input  logic          cpu_we,
    input  logic [AW-1:0] cpu_addr,
    input  logic [DW-1:0] cpu_wdata,
    output logic          cpu_gnt,
    input  logic          usb_req,
    input  logic          usb_eot,
    input  logic [DW-1:0] usb_wdata,
    output logic          usb_gnt,
    input  logic          dtc_req,
    input  logic [DW-1:0] dtc_wdata,
    output logic          dtc_gnt,
    output logic [DW-1:0] rd_data,
    output logic          bank_irq,
    output logic [1:0]    bank_owner,
    output logic          fill_bank,
    output logic          drain_bank,
    output logic [OW-1:0] fill_cnt,
    output logic [OW-1:0] drain_cnt
);
    localparam logic [OW-1:0] LAST_OFS = OW'(SECTOR_BYTES - 1);
    localparam logic [CW-1:0] FULL_LEN = CW'(SECTOR_BYTES);

    xfer_mode_e mode_q, mode_d;
    logic       dir_flip;

    bank_state_e   bank_st [2];
    logic [CW-1:0] len_q   [2];
    logic [1:0]    owner_w;

    logic fill_ok, drain_ok, usb_ok, dtc_ok;
    logic fill_gnt, drain_gnt, fill_close, drain_close, fill_eot;
    logic [DW-1:0] fill_wdata;
    logic [NUM_PORTS-1:0] arb_req, arb_ok, arb_gnt;

    logic          ram_en, ram_we;
    logic [AW-1:0] ram_addr;
    logic [DW-1:0] ram_wdata;

    // Direction register: a change of mode is the clearing event.
    assign mode_d   = dir_m2h ? MODE_M2H : MODE_H2M;
    assign dir_flip = (mode_d != mode_q);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mode_q <= MODE_H2M;
        else        mode_q <= mode_d;
    end

    // Per-bank ownership machines.
    generate
        for (genvar b = 0; b < 2; b++) begin : g_bank
            spb_bank_fsm u_fsm (
                .clk        (clk),
                .rst_n      (rst_n),
                .clr        (dir_flip),
                .fill_done  (fill_close  && (fill_bank  == b[0])),
                .drain_done (drain_close && (drain_bank == b[0])),
                .state      (bank_st[b])
            );
            assign owner_w[b] = (bank_st[b] == BANK_DRAIN);
        end
    endgenerate

    // Eligibility of the two streaming sides.
    always_comb begin
        fill_ok  = !dir_flip && !owner_w[fill_bank];
        drain_ok = !dir_flip &&  owner_w[drain_bank];
        unique case (mode_q)
            MODE_H2M: begin usb_ok = fill_ok;  dtc_ok = drain_ok; end
            MODE_M2H: begin usb_ok = drain_ok; dtc_ok = fill_ok;  end
            default:  begin usb_ok = 1'b0;     dtc_ok = 1'b0;     end
        endcase
    end

    assign arb_req[PORT_CPU] = cpu_req;
    assign arb_req[PORT_USB] = usb_req;
    assign arb_req[PORT_DTC] = dtc_req;
    assign arb_ok[PORT_CPU]  = 1'b1;
    assign arb_ok[PORT_USB]  = usb_ok;
    assign arb_ok[PORT_DTC]  = dtc_ok;

    spb_arbiter #(.N(NUM_PORTS)) u_arb (
        .req (arb_req),
        .ok  (arb_ok),
        .gnt (arb_gnt)
    );

    assign cpu_gnt = arb_gnt[PORT_CPU];
    assign usb_gnt = arb_gnt[PORT_USB];
    assign dtc_gnt = arb_gnt[PORT_DTC];

    // Role mapping and bank completion.
    always_comb begin
        unique case (mode_q)
            MODE_H2M: begin
                fill_gnt   = usb_gnt;
                drain_gnt  = dtc_gnt;
                fill_wdata = usb_wdata;
                fill_eot   = usb_eot;
            end
            MODE_M2H: begin
                fill_gnt   = dtc_gnt;
                drain_gnt  = usb_gnt;
                fill_wdata = dtc_wdata;
                fill_eot   = 1'b0;
            end
            default: begin
                fill_gnt   = 1'b0;
                drain_gnt  = 1'b0;
                fill_wdata = '0;
                fill_eot   = 1'b0;
            end
        endcase
        fill_close  = fill_gnt && ((fill_cnt == LAST_OFS) || fill_eot);
        drain_close = drain_gnt && (({1'b0, drain_cnt} + CW'(1)) == len_q[drain_bank]);
    end

    // RAM port mux (one access per cycle).
    always_comb begin
        ram_en    = cpu_gnt || fill_gnt || drain_gnt;
        ram_we    = cpu_gnt ? cpu_we : fill_gnt;
        ram_wdata = cpu_gnt ? cpu_wdata : fill_wdata;
        if (cpu_gnt)       ram_addr = cpu_addr;
        else if (fill_gnt) ram_addr = {fill_bank, fill_cnt};
        else               ram_addr = {drain_bank, drain_cnt};
    end

    spb_ram #(.DEPTH(2 * SECTOR_BYTES), .DW(DW)) u_ram (
        .clk   (clk),
        .en    (ram_en),
        .we    (ram_we),
        .addr  (ram_addr),
        .wdata (ram_wdata),
        .rdata (rd_data)
    );

    // Pointers, counters, lengths and interrupt.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fill_bank  <= 1'b0;
            drain_bank <= 1'b0;
            fill_cnt   <= '0;
            drain_cnt  <= '0;
            bank_irq   <= 1'b0;
            len_q[0]   <= FULL_LEN;
            len_q[1]   <= FULL_LEN;
        end else if (dir_flip) begin
            fill_bank  <= 1'b0;
            drain_bank <= 1'b0;
            fill_cnt   <= '0;
            drain_cnt  <= '0;
            bank_irq   <= 1'b0;
        end else begin
            bank_irq <= fill_close || drain_close;
            if (fill_gnt) begin
                if (fill_close) begin
                    len_q[fill_bank] <= {1'b0, fill_cnt} + CW'(1);
                    fill_bank        <= ~fill_bank;
                    fill_cnt         <= '0;
                end else begin
                    fill_cnt <= fill_cnt + OW'(1);
                end
            end
            if (drain_gnt) begin
                if (drain_close) begin
                    drain_bank <= ~drain_bank;
                    drain_cnt  <= '0;
                end else begin
                    drain_cnt <= drain_cnt + OW'(1);
                end
            end
        end
    end

    assign bank_owner = owner_w;
endmodule

// File: rtl/spb_checker.sv
module spb_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       cpu_req,
    input logic       cpu_gnt,
    input logic       usb_req,
    input logic       usb_ok,
    input logic       usb_gnt,
    input logic       dtc_gnt,
    input logic       fill_gnt,
    input logic       fill_bank,
    input logic       dir_flip,
    input logic       bank_irq,
    input logic [1:0] bank_owner
);
    AST_ONE_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({cpu_gnt, usb_gnt, dtc_gnt})); // R2

    AST_CPU_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_req |-> (cpu_gnt && !usb_gnt && !dtc_gnt)); // R2

    AST_USB_BEFORE_DTC: assert property (@(posedge clk) disable iff (!rst_n)
        (usb_req && usb_ok && !cpu_req) |-> !dtc_gnt); // R3

    AST_FILL_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        fill_gnt |-> !bank_owner[fill_bank]); // R7

    AST_IRQ_OWNER: assert property (@(posedge clk) disable iff (!rst_n)
        bank_irq |-> (bank_owner != $past(bank_owner))); // R9

    AST_DIR_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        dir_flip |=> (bank_owner == 2'b00 && !bank_irq)); // R10
endmodule

bind sector_pingpong_buf spb_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cpu_req    (cpu_req),
    .cpu_gnt    (cpu_gnt),
    .usb_req    (usb_req),
    .usb_ok     (usb_ok),
    .usb_gnt    (usb_gnt),
    .dtc_gnt    (dtc_gnt),
    .fill_gnt   (fill_gnt),
    .fill_bank  (fill_bank),
    .dir_flip   (dir_flip),
    .bank_irq   (bank_irq),
    .bank_owner (bank_owner)
);

// File: tb/sector_pingpong_buf_test.sv
module sector_pingpong_buf_test;
    localparam int SB = 512;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       dir_m2h = 1'b0;
    logic       cpu_req = 1'b0, cpu_we = 1'b0;
    logic [9:0] cpu_addr = '0;
    logic [7:0] cpu_wdata = '0;
    logic       usb_req = 1'b0, usb_eot = 1'b0;
    logic [7:0] usb_wdata = '0;
    logic       dtc_req = 1'b0;
    logic [7:0] dtc_wdata = '0;
    logic       cpu_gnt, usb_gnt, dtc_gnt, bank_irq, fill_bank, drain_bank;
    logic [7:0] rd_data;
    logic [1:0] bank_owner;
    logic [8:0] fill_cnt, drain_cnt;

    always #5 clk = ~clk;

    sector_pingpong_buf uut (
        .clk(clk), .rst_n(rst_n), .dir_m2h(dir_m2h),
        .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_gnt(cpu_gnt),
        .usb_req(usb_req), .usb_eot(usb_eot), .usb_wdata(usb_wdata), .usb_gnt(usb_gnt),
        .dtc_req(dtc_req), .dtc_wdata(dtc_wdata), .dtc_gnt(dtc_gnt),
        .rd_data(rd_data), .bank_irq(bank_irq), .bank_owner(bank_owner),
        .fill_bank(fill_bank), .drain_bank(drain_bank), .fill_cnt(fill_cnt), .drain_cnt(drain_cnt)
    );

    int total = 0, bad = 0, cyc = 0;
    bit done = 0;

    // Reference model state
    int  own [2];
    int  lenm [2];
    int  mem [2*SB];
    int  fb, db, fc, dc;
    bit  prev_dir, exp_irq, rd_pend, fresh;
    int  rd_exp;
    string close_tag;

    task automatic chk(int act, int exp, string tag, string what);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d (cycle %0d)", tag, what, act, exp, cyc);
        end
    endtask

    task automatic model_reset();
        own[0] = 0; own[1] = 0; lenm[0] = SB; lenm[1] = SB;
        fb = 0; db = 0; fc = 0; dc = 0;
        exp_irq = 0; rd_pend = 0; close_tag = "";
    endtask

    initial begin
        model_reset();
        prev_dir = 0;
        for (int i = 0; i < 2*SB; i++) mem[i] = 0;
    end

    always @(negedge clk) begin
        cyc++;
        if (!rst_n) begin
            model_reset();
            prev_dir = 0;
            fresh = 1;
        end else if (!done) begin
            bit clr, fill_ok, drain_ok, e_usb, e_dtc, g_cpu, g_usb, g_dtc, f_g, d_g, fill_is_usb;
            if (fresh) begin
                chk(bank_owner, 0, "R12", "owners after reset");
                chk(fill_cnt + drain_cnt + fill_bank + drain_bank, 0, "R12", "pointers after reset");
                chk(bank_irq, 0, "R12", "irq after reset");
                fresh = 0;
            end
            // registered results of the previous edge
            if (rd_pend) chk(rd_data, rd_exp, "R8", "read data");
            chk(bank_irq, exp_irq, "R9", "handover interrupt");
            chk({bank_owner, fill_bank, drain_bank}, {own[1][0], own[0][0], fb[0], db[0]}, "R11", "owners/pointers");
            chk({fill_cnt, drain_cnt}, {fc[8:0], dc[8:0]}, "R11", "counters");
            if (close_tag != "") chk(bank_owner, {own[1][0], own[0][0]}, close_tag, "owner after handover");
            close_tag = "";
            // combinational grants
            clr = (dir_m2h != prev_dir);
            fill_ok  = !clr && own[fb] == 0;
            drain_ok = !clr && own[db] == 1;
            fill_is_usb = !prev_dir;
            e_usb = fill_is_usb ? fill_ok : drain_ok;
            e_dtc = fill_is_usb ? drain_ok : fill_ok;
            g_cpu = cpu_req;
            g_usb = usb_req && e_usb && !cpu_req;
            g_dtc = dtc_req && e_dtc && !cpu_req && !g_usb;
            chk(cpu_gnt, g_cpu, "R2", "cpu grant");
            chk(usb_gnt, g_usb, clr ? "R10" : (cpu_req ? "R2" : "R3"), "usb grant");
            chk(dtc_gnt, g_dtc, clr ? "R10" : (usb_req && e_usb ? "R3" : "R7"), "dtc grant");
            if (usb_req && !e_usb && !clr) chk(usb_gnt, 0, "R7", "usb stall");
            // model update for the coming edge
            rd_pend = 0; exp_irq = 0;
            if (clr) begin
                own[0] = 0; own[1] = 0; fb = 0; db = 0; fc = 0; dc = 0;
                prev_dir = dir_m2h;
            end else begin
                f_g = fill_is_usb ? g_usb : g_dtc;
                d_g = fill_is_usb ? g_dtc : g_usb;
                if (g_cpu) begin
                    if (cpu_we) mem[cpu_addr] = cpu_wdata;
                    else begin rd_exp = mem[cpu_addr]; rd_pend = 1; end   // R1
                end
                if (f_g) begin
                    mem[fb*SB + fc] = fill_is_usb ? usb_wdata : dtc_wdata;  // R4
                    if (fc == SB-1 || (fill_is_usb && usb_eot)) begin
                        close_tag = (fc == SB-1) ? "R5" : "R6";
                        lenm[fb] = fc + 1; own[fb] = 1; fb ^= 1; fc = 0; exp_irq = 1;
                    end else fc++;
                end
                if (d_g) begin
                    rd_exp = mem[db*SB + dc]; rd_pend = 1;   // R4 drain order
                    if (dc + 1 == lenm[db]) begin
                        close_tag = "R8";
                        own[db] = 0; db ^= 1; dc = 0; exp_irq = 1;
                    end else dc++;
                end
            end
        end
    end

    task automatic tick();
        @(posedge clk); #1;
        usb_wdata = 8'($urandom);
        dtc_wdata = 8'($urandom);
    endtask

    task automatic run(int n, int cpu_every, int eot_every);
        for (int i = 0; i < n; i++) begin
            cpu_req   = (cpu_every != 0) && ($urandom % cpu_every == 0);
            cpu_we    = 1'($urandom);
            cpu_addr  = 10'($urandom);
            cpu_wdata = 8'($urandom);
            usb_eot   = (eot_every != 0) && ($urandom % eot_every == 0);
            tick();
        end
        cpu_req = 0; usb_eot = 0;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        // H2M: USB fills both banks then stalls (R5, R7)
        usb_req = 1;
        run(1200, 0, 0);
        // coprocessor drains while USB refills, CPU contends (R2, R3, R4)
        dtc_req = 1;
        run(2500, 7, 0);
        // short transfers close banks early (R6)
        run(2500, 9, 90);
        // CPU-only burst reading and writing (R1)
        usb_req = 0; dtc_req = 0;
        run(200, 1, 0);
        usb_req = 1; dtc_req = 1;
        // reverse direction: coprocessor fills, USB drains, eot must be ignored (R10, R4, R6)
        dir_m2h = 1;
        run(3000, 11, 40);
        // flip back mid-stream (R10)
        dir_m2h = 0;
        run(1500, 13, 120);
        usb_req = 0; dtc_req = 0;
        run(5, 0, 0);
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        done = 1;
        total++; bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule